// File: doc/BRIEF.md
# Single-Clock FIFO with Direction-Resolved Flags

This block is a first-in first-out buffer on one clock. It holds exactly `DEPTH` entries in `DEPTH` storage words and wastes no spare location. The read and write pointers are plain counters that wrap at `DEPTH`. When the two pointers are equal, the buffer is either completely empty or completely full. One flip-flop records whether the most recent pointer movement was a write or a read, and that bit settles which of the two cases applies. The empty and full flags therefore need only one equality compare of the pointers and no pointer arithmetic.

A producer raises `wr_en` with `wr_data`. A consumer sees the oldest stored entry on `rd_data` whenever the buffer is not empty, and raises `rd_en` to remove it. An optional half-full flag, enabled by a parameter, signals when at least half of the locations are occupied.

All three flags are decoded from registered state only. Each flag therefore changes right after the clock edge that accepts an operation.

Top module: `dirq_fifo`

## Requirements
- R1: After a synchronous active-high reset, `empty` is 1, `full` is 0 and `half_full` is 0.
- R2: Entries leave in the order they were accepted. `rd_data` shows the oldest entry whenever `empty` is 0.
- R3: Starting from empty, exactly `DEPTH` accepted writes with no reads make `full` 1. The last of them is the first to set it.
- R4: A write while `full` is 1 and no read is requested is ignored. `full` stays 1 and the stored contents are unchanged.
- R5: A read while `empty` is 1 and no write is requested is ignored, and `empty` stays 1.
- R6: A read and a write in the same cycle, while the buffer is neither empty nor full, both take effect. The occupancy stays the same.
- R7: A read and a write in the same cycle while `full` is 1: the read is accepted and the write is ignored. The buffer is then left holding `DEPTH-1` entries.
- R8: A read and a write in the same cycle while `empty` is 1: the write is accepted and the read is ignored. The buffer is then left holding 1 entry, which is the written value.
- R9: `half_full` is 1 exactly when the occupancy is at least `DEPTH/2`.
- R10: `full` and `empty` are never 1 together. Each reflects the occupancy right after the edge that changed it.
- R11: The pointers wrap from `DEPTH-1` to 0, and repeated fill and drain rounds keep the FIFO order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Data to store |
| rd_en | input | 1 | Read request (removes the head entry) |
| rd_data | output | WIDTH | Oldest stored entry |
| full | output | 1 | All DEPTH locations occupied |
| empty | output | 1 | No entry stored |
| half_full | output | 1 | Occupancy at least DEPTH/2 (0 when disabled) |

## Verification
Flags and `rd_data` are combinational functions of the registered pointers and the direction bit. An accepted operation is therefore visible one clock edge later, with no further delay. The bench drives inputs one nanosecond after a rising edge. It checks `rd_data` before the edge that pops the entry, and checks the flags one nanosecond after that edge, against a queue model updated by the acceptance rules in R4, R5, R7 and R8. That keeps every comparison in the first settled instant after the edge responsible for it.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

    // Kind of the most recent one-sided pointer movement
    typedef enum logic {
        LAST_READ  = 1'b0,
        LAST_WRITE = 1'b1
    } last_move_e;

    // Accepted operations in one cycle
    typedef struct packed {
        logic wr;
        logic rd;
    } grant_t;

    // Direction bit update: only a one-sided move changes it
    function automatic last_move_e next_dir(last_move_e cur, grant_t g);
        if (g.wr && !g.rd) return LAST_WRITE;
        if (g.rd && !g.wr) return LAST_READ;
        return cur;
    endfunction

endpackage

// File: rtl/dirq_ptr.sv
module dirq_ptr #(
    parameter int DEPTH = 8,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    // R11: pointer never leaves 0..DEPTH-1 and wraps to zero
    a_r11_ptr_range: assert property (@(posedge clk) disable iff (rst)
        ptr <= LAST);
    a_r11_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && ptr == LAST) |=> ptr == '0);

endmodule

// File: rtl/dirq_store.sv
module dirq_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/dirq_track.sv
module dirq_track
    import dirq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int PW      = $clog2(DEPTH),
    parameter bit HALF_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic [PW-1:0] wr_ptr,
    input  logic [PW-1:0] rd_ptr,
    output grant_t        grant,
    output logic          full,
    output logic          empty,
    output logic          half_full
);
    localparam int CW = PW + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);

    last_move_e    dir_q;
    logic          same;
    logic [CW-1:0] span;
    logic [CW-1:0] count;

    // Single equality compare feeds both end flags
    assign same  = (wr_ptr == rd_ptr);
    assign full  = same && (dir_q == LAST_WRITE);
    assign empty = same && (dir_q == LAST_READ);

    assign grant.wr = wr_req && !full;
    assign grant.rd = rd_req && !empty;

    always_ff @(posedge clk) begin
        if (rst)
            dir_q <= LAST_READ;
        else
            dir_q <= next_dir(dir_q, grant);
    end

    // Occupancy only for the half mark
    always_comb begin
        if (wr_ptr >= rd_ptr)
            span = {1'b0, wr_ptr} - {1'b0, rd_ptr};
        else
            span = {1'b0, wr_ptr} + DEPTH_C - {1'b0, rd_ptr};
        if (same)
            count = (dir_q == LAST_WRITE) ? DEPTH_C : '0;
        else
            count = span;
    end

    generate
        if (HALF_EN) begin : g_half
            assign half_full = (count >= HALF_C);
        end else begin : g_no_half
            assign half_full = 1'b0;
        end
    endgenerate

    // R10: ends are exclusive
    a_r10_not_both: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));
    // R3: full only rises after an accepted write
    a_r3_full_by_write: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(grant.wr) && !$past(grant.rd));
    // R4: overflow attempt changes nothing
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (full && wr_req && !rd_req) |=> full && $stable(wr_ptr) && $stable(rd_ptr));
    // R5: underflow attempt changes nothing
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_req && !wr_req) |=> empty && $stable(wr_ptr) && $stable(rd_ptr));
    // R6: balanced cycle keeps occupancy
    a_r6_both_keep: assert property (@(posedge clk) disable iff (rst)
        (!full && !empty && wr_req && rd_req) |=> $stable(count) && !full && !empty);
    // R7: both at full drain one
    a_r7_both_full: assert property (@(posedge clk) disable iff (rst)
        (full && wr_req && rd_req) |=> !full && count == DEPTH_C - 1'b1);
    // R8: both at empty store one
    a_r8_both_empty: assert property (@(posedge clk) disable iff (rst)
        (empty && wr_req && rd_req) |=> !empty && count == CW'(1));

endmodule

// File: rtl/dirq_fifo.sv
module dirq_fifo
    import dirq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int WIDTH   = 16,
    parameter bit HALF_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty,
    output logic             half_full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    grant_t        grant;
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    dirq_track #(.DEPTH(DEPTH), .PW(PW), .HALF_EN(HALF_EN)) u_track (
        .clk       (clk),
        .rst       (rst),
        .wr_req    (wr_en),
        .rd_req    (rd_en),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .grant     (grant),
        .full      (full),
        .empty     (empty),
        .half_full (half_full)
    );

    dirq_ptr #(.DEPTH(DEPTH), .PW(PW)) u_wr_ptr (
        .clk (clk),
        .rst (rst),
        .adv (grant.wr),
        .ptr (wr_ptr)
    );

    dirq_ptr #(.DEPTH(DEPTH), .PW(PW)) u_rd_ptr (
        .clk (clk),
        .rst (rst),
        .adv (grant.rd),
        .ptr (rd_ptr)
    );

    dirq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PW(PW)) u_store (
        .clk   (clk),
        .we    (grant.wr),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .raddr (rd_ptr),
        .rdata (rd_data)
    );

    // R1: state right after reset
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> empty && !full && !half_full);

endmodule

// File: tb/test_dirq_fifo.sv
`timescale 1ns/1ps
module test_dirq_fifo;
    localparam int DEPTH = 8;
    localparam int WIDTH = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             rd_en = 1'b0;
    logic [WIDTH-1:0] rd_data;
    logic             full, empty, half_full;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [WIDTH-1:0] q[$];

    always #10 clk = ~clk;

    dirq_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .HALF_EN(1'b1)) i_dirq_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .full(full), .empty(empty), .half_full(half_full)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Flags against the queue model (R10 exclusivity implied by the model)
    task automatic chk_flags(string tag);
        chk(tag, "empty", int'(empty), int'(q.size() == 0));
        chk(tag, "full", int'(full), int'(q.size() == DEPTH));
        chk({tag, "/R9"}, "half_full", int'(half_full), int'(q.size() >= DEPTH / 2));
        chk("R10", "full&empty", int'(full && empty), 0);
    endtask

    // One clock cycle; inputs set 1 ns after an edge, flags checked 1 ns after the next
    task automatic cycle(bit w, logic [WIDTH-1:0] d, bit r, string tag);
        bit wa, ra;
        wr_en = w; wr_data = d; rd_en = r;
        #5;
        if (q.size() > 0) chk({tag, "/R2"}, "rd_data", int'(rd_data), int'(q[0]));
        wa = w && (q.size() < DEPTH);
        ra = r && (q.size() > 0);
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0;
        if (ra) void'(q.pop_front());
        if (wa) q.push_back(d);
        chk_flags(tag);
    endtask

    task automatic t_reset();
        chk("R1", "empty", int'(empty), 1);
        chk("R1", "full", int'(full), 0);
        chk("R1", "half_full", int'(half_full), 0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < DEPTH; i++) begin
            cycle(1'b1, WIDTH'(16'hA000 + i), 1'b0, "R3");
            chk("R3", "full_early", int'(full), int'(i == DEPTH - 1));
        end
    endtask

    task automatic t_overflow();
        cycle(1'b1, 16'hDEAD, 1'b0, "R4");
        cycle(1'b1, 16'hDEAD, 1'b0, "R4");
        chk("R4", "full_kept", int'(full), 1);
        chk("R4", "head_kept", int'(rd_data), 16'hA000);
    endtask

    task automatic t_both_full();
        cycle(1'b1, 16'hB7B7, 1'b1, "R7");
        chk("R7", "full_after", int'(full), 0);
        chk("R7", "count", q.size(), DEPTH - 1);
    endtask

    task automatic t_drain(string tag);
        while (q.size() > 0) cycle(1'b0, '0, 1'b1, tag);
        chk(tag, "empty_end", int'(empty), 1);
    endtask

    task automatic t_underflow();
        cycle(1'b0, '0, 1'b1, "R5");
        cycle(1'b0, '0, 1'b1, "R5");
        chk("R5", "empty_kept", int'(empty), 1);
        cycle(1'b1, 16'hBEEF, 1'b0, "R5");
        chk("R5", "data_after", int'(rd_data), 16'hBEEF);
        t_drain("R5");
    endtask

    task automatic t_both_empty();
        cycle(1'b1, 16'h5A5A, 1'b1, "R8");
        chk("R8", "not_empty", int'(empty), 0);
        chk("R8", "data", int'(rd_data), 16'h5A5A);
        t_drain("R8");
    endtask

    task automatic t_both_mid();
        for (int i = 0; i < 3; i++) cycle(1'b1, WIDTH'(16'hC000 + i), 1'b0, "R6");
        for (int i = 0; i < 6; i++) begin
            cycle(1'b1, WIDTH'(16'hC100 + i), 1'b1, "R6");
            chk("R6", "count_kept", q.size(), 3);
        end
        for (int i = 0; i < 2; i++) cycle(1'b1, WIDTH'(16'hC200 + i), 1'b0, "R6");
        chk("R9", "half_at_5", int'(half_full), 1);
        t_drain("R6");
    endtask

    task automatic t_wrap();
        for (int round = 0; round < 4; round++) begin
            for (int i = 0; i < 5; i++) cycle(1'b1, WIDTH'((round << 8) + i + 1), 1'b0, "R11");
            t_drain("R11");
        end
        for (int i = 0; i < DEPTH; i++) cycle(1'b1, WIDTH'(16'hE000 + i), 1'b0, "R11");
        chk("R11", "full_after_wrap", int'(full), 1);
        t_drain("R11");
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_fill();
        t_overflow();
        t_both_full();
        t_drain("R2");
        t_underflow();
        t_both_empty();
        t_both_mid();
        t_wrap();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule